// File: doc/BRIEF.md
# VLAN table command engine

This block keeps a small table of VLAN entries inside a switch. Each entry holds a valid flag, a 12-bit VLAN ID and a member port mask. Software changes the table through two registers on a simple write/read port. It first writes a data register that carries a member mask and a valid flag. It then writes a command register that carries an opcode, a VLAN ID, a port number and a priority. The engine runs the command by stepping through the table one entry per cycle. It shows that it is working through the active bit of the command register, which clears by itself when the command is done.

The forwarding logic asks questions of the table through a lookup port. It presents a VLAN ID and gets back, in the same cycle, whether a valid entry holds that ID and that entry's member mask. The supported commands are no-op, flush, load, purge and remove-port. A load that finds no usable entry raises a table-full flag in the command register.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset every entry is invalid, both registers read as zero, and a lookup of any VLAN ID returns hit 0 with mask 0.
- R2: The command word is laid out as follows: opcode in bits [2:0], active in bit 3, full in bit 4, port in [11:8], VLAN ID in [27:16], priority in [30:28], priority enable in bit 31. The remaining bits read as zero. A command write with bit 3 set while the engine is idle starts the command and stores its fields, which read back unchanged. Bit 3 reads 1 while the command runs. A command write with bit 3 clear changes nothing.
- R3: Flush, purge, remove-port, no-op and the unused opcodes 5 to 7 (which behave as no-op) keep the active bit high for exactly NUM_ENTRIES cycles after the write. Load keeps it high for exactly NUM_ENTRIES+1 cycles. The active bit is low afterwards.
- R4: While the active bit is high, writes to the command register and writes to the data register are both ignored.
- R5: The data register holds the member mask in bits [9:0] and the valid flag in bit 11, and the other bits read as zero. Load (opcode 2) with the valid flag set writes the mask into the entry whose VLAN ID matches. If no entry matches, it writes the ID and mask into the lowest-numbered invalid entry. No two valid entries ever share a VLAN ID.
- R6: A load with the valid flag set that finds neither a matching entry nor an invalid entry sets the full bit (bit 4) and leaves the table unchanged. The full bit clears when the next command starts.
- R7: Flush (opcode 1) invalidates every entry.
- R8: Purge (opcode 3) invalidates only the entry whose VLAN ID matches the command's VLAN ID.
- R9: Remove-port (opcode 4) clears the mask bit for the command's port in every valid entry. A port number of 10 or more changes nothing.
- R10: The lookup port returns hit 1 and the stored mask when a valid entry matches. Otherwise it returns hit 0 and mask 0.
- R11: A load with the valid flag clear invalidates the matching entry if there is one. It never claims an invalid entry and never sets the full bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| lk_vid | input | 12 | VLAN ID to look up |
| lk_hit | output | 1 | A valid entry holds lk_vid |
| lk_mask | output | 10 | Member mask of the matching entry, zero on a miss |

## Verification
The bench loads the same VLAN ID a second time and expects the existing entry to be updated in place. A design that skipped the match search would create a duplicate entry, or would run out of entries one load too early. It fills all sixteen entries and then loads a new ID, expecting the full bit to be set and the table to be untouched. It then loads an ID that is already present and expects the full bit to clear, which catches a full check that fires before the match search. It also writes both registers in the middle of a running load, removes a port number that lies outside the mask, and counts the active cycles of every command. These tests expose a design that accepts writes while busy, wraps the port shift into the mask, or ends a command one cycle early or late.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;
  localparam int VID_W  = 12;
  localparam int MASK_W = 10;
  localparam int PORT_W = 4;
  localparam int OP_W   = 3;
  localparam int PRIO_W = 3;
  localparam int REG_W  = 32;

  // field positions of the command word
  localparam int CMD_OP_LSB   = 0;
  localparam int CMD_ACT_BIT  = 3;
  localparam int CMD_FULL_BIT = 4;
  localparam int CMD_PORT_LSB = 8;
  localparam int CMD_VID_LSB  = 16;
  localparam int CMD_PRIO_LSB = 28;
  localparam int CMD_PEN_BIT  = 31;
  // field positions of the data word
  localparam int DAT_MASK_LSB  = 0;
  localparam int DAT_VALID_BIT = 11;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 3'd0,
    OP_FLUSH  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_PURGE  = 3'd3,
    OP_RMPORT = 3'd4
  } vop_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SCAN   = 2'd1,
    PH_COMMIT = 2'd2
  } phase_e;

  typedef struct packed {
    logic              valid;
    logic [VID_W-1:0]  vid;
    logic [MASK_W-1:0] mask;
  } ventry_t;
endpackage

// File: rtl/vlan_table_store.sv
module vlan_table_store
  import vlan_cmd_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  ventry_t                wr_entry,
  input  logic [IDX_W-1:0]       rd_idx,
  output ventry_t                rd_entry,
  input  logic [VID_W-1:0]       lk_vid,
  output logic                   lk_hit,
  output logic [MASK_W-1:0]      lk_mask,
  output logic [NUM_ENTRIES-1:0] valid_vec,
  output logic [NUM_ENTRIES-1:0] hit_vec
);
  ventry_t ent_arr [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    ventry_t ent_q;
    logic    ent_we;

    assign ent_we = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_we) begin
        ent_q <= wr_entry;
      end
    end

    assign ent_arr[g]   = ent_q;
    assign valid_vec[g] = ent_q.valid;
    assign hit_vec[g]   = ent_q.valid && (ent_q.vid == lk_vid);
  end

  assign rd_entry = ent_arr[rd_idx];

  // lowest matching index wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_mask = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        lk_hit  = 1'b1;
        lk_mask = ent_arr[i].mask;
      end
    end
  end
endmodule

// File: rtl/vlan_cmd_seq.sv
module vlan_cmd_seq
  import vlan_cmd_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [VID_W-1:0]  cmd_vid,
  input  logic [PORT_W-1:0] cmd_port,
  input  logic [MASK_W-1:0] dat_mask,
  input  logic              dat_valid,
  input  ventry_t           rd_entry,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output ventry_t           wr_entry,
  output logic              busy,
  output logic              full_set
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  phase_e            phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              mfound_q, mfound_d;
  logic [IDX_W-1:0]  midx_q, midx_d;
  logic              ffound_q, ffound_d;
  logic [IDX_W-1:0]  fidx_q, fidx_d;
  logic              cur_hit;
  logic [MASK_W-1:0] clr_mask;

  assign cur_hit  = rd_entry.valid && (rd_entry.vid == cmd_vid);
  assign clr_mask = (32'(cmd_port) < MASK_W) ? (MASK_W'(1) << cmd_port) : '0;
  assign rd_idx   = idx_q;
  assign busy     = (phase_q != PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    mfound_d = mfound_q;
    midx_d   = midx_q;
    ffound_d = ffound_q;
    fidx_d   = fidx_q;
    wr_en    = 1'b0;
    wr_idx   = idx_q;
    wr_entry = rd_entry;
    full_set = 1'b0;

    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d  = PH_SCAN;
          idx_d    = '0;
          mfound_d = 1'b0;
          ffound_d = 1'b0;
        end
      end
      PH_SCAN: begin
        case (op)
          OP_FLUSH: begin
            wr_en          = 1'b1;
            wr_entry.valid = 1'b0;
          end
          OP_PURGE: begin
            wr_en          = cur_hit;
            wr_entry.valid = 1'b0;
          end
          OP_RMPORT: begin
            wr_en         = rd_entry.valid;
            wr_entry.mask = rd_entry.mask & ~clr_mask;
          end
          OP_LOAD: begin
            if (cur_hit && !mfound_q) begin
              mfound_d = 1'b1;
              midx_d   = idx_q;
            end
            if (!rd_entry.valid && !ffound_q) begin
              ffound_d = 1'b1;
              fidx_d   = idx_q;
            end
          end
          default: ;
        endcase
        if (idx_q == LAST_IDX) begin
          phase_d = (op == OP_LOAD) ? PH_COMMIT : PH_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      PH_COMMIT: begin
        phase_d        = PH_IDLE;
        wr_entry.valid = dat_valid;
        wr_entry.vid   = cmd_vid;
        wr_entry.mask  = dat_mask;
        if (mfound_q) begin
          wr_en  = 1'b1;
          wr_idx = midx_q;
        end else if (dat_valid && ffound_q) begin
          wr_en  = 1'b1;
          wr_idx = fidx_q;
        end else if (dat_valid) begin
          full_set = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      mfound_q <= 1'b0;
      midx_q   <= '0;
      ffound_q <= 1'b0;
      fidx_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      mfound_q <= mfound_d;
      midx_q   <= midx_d;
      ffound_q <= ffound_d;
      fidx_q   <= fidx_d;
    end
  end
endmodule

// File: rtl/vlan_cmd_regs.sv
module vlan_cmd_regs
  import vlan_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              full_set,
  output logic              start,
  output logic [OP_W-1:0]   op_q,
  output logic [VID_W-1:0]  vid_q,
  output logic [PORT_W-1:0] port_q,
  output logic [MASK_W-1:0] dmask_q,
  output logic              dvalid_q,
  output logic              full_q
);
  logic [PRIO_W-1:0] prio_q;
  logic              pen_q;
  logic              cmd_we, data_we, full_d;
  logic [REG_W-1:0]  cmd_word, data_word;

  assign cmd_we  = reg_wr && !reg_sel && reg_wdata[CMD_ACT_BIT] && !busy;
  assign data_we = reg_wr && reg_sel && !busy;
  assign start   = cmd_we;

  always_comb begin
    full_d = full_q;
    if (cmd_we) begin
      full_d = 1'b0;
    end else if (full_set) begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= '0;
      vid_q    <= '0;
      port_q   <= '0;
      prio_q   <= '0;
      pen_q    <= 1'b0;
      dmask_q  <= '0;
      dvalid_q <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      if (cmd_we) begin
        op_q   <= reg_wdata[CMD_OP_LSB +: OP_W];
        vid_q  <= reg_wdata[CMD_VID_LSB +: VID_W];
        port_q <= reg_wdata[CMD_PORT_LSB +: PORT_W];
        prio_q <= reg_wdata[CMD_PRIO_LSB +: PRIO_W];
        pen_q  <= reg_wdata[CMD_PEN_BIT];
      end
      if (data_we) begin
        dmask_q  <= reg_wdata[DAT_MASK_LSB +: MASK_W];
        dvalid_q <= reg_wdata[DAT_VALID_BIT];
      end
      full_q <= full_d;
    end
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_OP_LSB +: OP_W]     = op_q;
    cmd_word[CMD_ACT_BIT]            = busy;
    cmd_word[CMD_FULL_BIT]           = full_q;
    cmd_word[CMD_PORT_LSB +: PORT_W] = port_q;
    cmd_word[CMD_VID_LSB +: VID_W]   = vid_q;
    cmd_word[CMD_PRIO_LSB +: PRIO_W] = prio_q;
    cmd_word[CMD_PEN_BIT]            = pen_q;

    data_word = '0;
    data_word[DAT_MASK_LSB +: MASK_W] = dmask_q;
    data_word[DAT_VALID_BIT]          = dvalid_q;

    reg_rdata = reg_sel ? data_word : cmd_word;
  end
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vlan_cmd_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [1:0]             rst_sync_q;
  logic                   rst_sync_n;
  logic                   start, busy, full_set, full_q;
  logic [OP_W-1:0]        op_q;
  logic [VID_W-1:0]       vid_q;
  logic [PORT_W-1:0]      port_q;
  logic [MASK_W-1:0]      dmask_q;
  logic                   dvalid_q;
  logic [IDX_W-1:0]       rd_idx, wr_idx;
  logic                   wr_en;
  ventry_t                rd_entry, wr_entry;
  logic [NUM_ENTRIES-1:0] valid_vec, hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  vlan_cmd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .full_set (full_set),
    .start    (start),
    .op_q     (op_q),
    .vid_q    (vid_q),
    .port_q   (port_q),
    .dmask_q  (dmask_q),
    .dvalid_q (dvalid_q),
    .full_q   (full_q)
  );

  vlan_cmd_seq #(.NUM_ENTRIES(NUM_ENTRIES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .op       (op_q),
    .cmd_vid  (vid_q),
    .cmd_port (port_q),
    .dat_mask (dmask_q),
    .dat_valid(dvalid_q),
    .rd_entry (rd_entry),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .busy     (busy),
    .full_set (full_set)
  );

  vlan_table_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .rd_idx   (rd_idx),
    .rd_entry (rd_entry),
    .lk_vid   (lk_vid),
    .lk_hit   (lk_hit),
    .lk_mask  (lk_mask),
    .valid_vec(valid_vec),
    .hit_vec  (hit_vec)
  );
endmodule

// File: rtl/vlan_cmd_engine_chk.sv
module vlan_cmd_engine_chk
  import vlan_cmd_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic                   reg_sel,
  input logic [REG_W-1:0]       reg_wdata,
  input logic                   busy,
  input logic [OP_W-1:0]        op_q,
  input logic [VID_W-1:0]       vid_q,
  input logic [MASK_W-1:0]      dmask_q,
  input logic                   dvalid_q,
  input logic                   full_q,
  input logic [NUM_ENTRIES-1:0] valid_vec,
  input logic [NUM_ENTRIES-1:0] hit_vec
);
  localparam int CW = $clog2(NUM_ENTRIES + 2) + 1;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end else begin
      busy_cnt <= '0;
    end
  end

  AST_OP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(NUM_ENTRIES + 1)); // R3

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && !reg_sel && reg_wdata[CMD_ACT_BIT])); // R2

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({dvalid_q, dmask_q})); // R4

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({op_q, vid_q})); // R4

  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> ($fell(busy) && op_q == OP_LOAD)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op_q == OP_FLUSH) |-> (valid_vec == '0)); // R7

  AST_UNIQUE_VID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R5
endmodule

bind vlan_cmd_engine vlan_cmd_engine_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .reg_wdata(reg_wdata),
  .busy     (busy),
  .op_q     (op_q),
  .vid_q    (vid_q),
  .dmask_q  (dmask_q),
  .dvalid_q (dvalid_q),
  .full_q   (full_q),
  .valid_vec(valid_vec),
  .hit_vec  (hit_vec)
);

// File: tb/vlan_cmd_engine_bench.sv
module vlan_cmd_engine_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] lk_vid = '0;
  logic        lk_hit;
  logic [9:0]  lk_mask;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vlan_cmd_engine #(.NUM_ENTRIES(N)) u_vlan_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_mask(lk_mask)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] vid;
    logic [3:0]  port;
    logic        dv;
    logic [9:0]  dm;
    logic [11:0] qv;
    logic        qh;
    logic [9:0]  qm;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 12'd10, 4'd0,  1'b1, 10'h003, 12'd10, 1'b1, 10'h003, 4'd5},  // R5 new entry
    '{3'd2, 12'd20, 4'd0,  1'b1, 10'h00C, 12'd20, 1'b1, 10'h00C, 4'd5},  // R5 second entry
    '{3'd2, 12'd10, 4'd0,  1'b1, 10'h3F0, 12'd10, 1'b1, 10'h3F0, 4'd5},  // R5 update in place
    '{3'd4, 12'd0,  4'd5,  1'b0, 10'h000, 12'd10, 1'b1, 10'h3D0, 4'd9},  // R9 drop port 5
    '{3'd4, 12'd0,  4'd12, 1'b0, 10'h000, 12'd10, 1'b1, 10'h3D0, 4'd9},  // R9 port out of range
    '{3'd3, 12'd20, 4'd0,  1'b0, 10'h000, 12'd20, 1'b0, 10'h000, 4'd8},  // R8 purge hit
    '{3'd3, 12'd99, 4'd0,  1'b0, 10'h000, 12'd10, 1'b1, 10'h3D0, 4'd8},  // R8 purge other id
    '{3'd2, 12'd30, 4'd0,  1'b1, 10'h200, 12'd30, 1'b1, 10'h200, 4'd5},  // R5 reuse freed entry
    '{3'd2, 12'd30, 4'd0,  1'b0, 10'h000, 12'd30, 1'b0, 10'h000, 4'd11}, // R11 invalidating load
    '{3'd1, 12'd0,  4'd0,  1'b0, 10'h000, 12'd10, 1'b0, 10'h000, 4'd7}   // R7 flush
  };

  function automatic logic [31:0] cmdw(input logic [2:0] op, input logic [11:0] vid,
                                       input logic [3:0] port, input logic [2:0] prio,
                                       input logic pen, input logic act);
    return {pen, prio, vid, 4'h0, port, 3'b000, 1'b0, act, op};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (reg_rdata[3] && cyc < 64) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [31:0] cmd, output int cyc);
    wr(1'b0, cmd);
    wait_idle(cyc);
  endtask

  task automatic data(input logic v, input logic [9:0] m);
    wr(1'b1, {20'h0, v, 1'b0, m});
  endtask

  task automatic look(input logic [11:0] vid, input logic eh, input logic [9:0] em, input string tag);
    lk_vid = vid;
    #1;
    chk(tag, {21'h0, lk_hit, lk_mask}, {21'h0, eh, em});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_sel = 1'b0; #1;
    chk("R1 command reads zero", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1;
    chk("R1 data reads zero", reg_rdata, 32'h0);
    reg_sel = 1'b0;
    look(12'd0, 1'b0, 10'h0, "R1 lookup misses");

    // vector table
    for (int i = 0; i < NV; i++) begin
      data(VECS[i].dv, VECS[i].dm);
      run(cmdw(VECS[i].op, VECS[i].vid, VECS[i].port, 3'd0, 1'b0, 1'b1), cyc);
      chk($sformatf("R3 vec%0d active cycles", i), cyc,
          (VECS[i].op == 3'd2) ? N + 1 : N);
      look(VECS[i].qv, VECS[i].qh, VECS[i].qm, $sformatf("R%0d vec%0d lookup", VECS[i].req, i));
    end
    look(12'd30, 1'b0, 10'h0, "R10 miss returns zero mask");

    // R2 active visible, field readback
    wr(1'b0, cmdw(3'd0, 12'hABC, 4'd7, 3'd5, 1'b1, 1'b1));
    chk("R2 active bit during command", {31'h0, reg_rdata[3]}, 32'h1);
    wait_idle(cyc);
    chk("R2 field readback", reg_rdata, 32'hDABC0700);
    wr(1'b0, 32'h0037_0002);
    chk("R2 write without active bit ignored", reg_rdata, 32'hDABC0700);
    look(12'h037, 1'b0, 10'h0, "R2 no load from inactive write");

    // R3 unused opcode acts as no-op
    run(cmdw(3'd6, 12'd1, 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    chk("R3 opcode 6 cycles", cyc, N);

    // R6 fill the table
    for (int i = 0; i < N; i++) begin
      data(1'b1, 10'(i));
      run(cmdw(3'd2, 12'(100 + i), 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    end
    data(1'b1, 10'h155);
    run(cmdw(3'd2, 12'd200, 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    chk("R6 full flag set", {31'h0, reg_rdata[4]}, 32'h1);
    chk("R6 full load cycles", cyc, N + 1);
    look(12'd200, 1'b0, 10'h0, "R6 table unchanged by full load");
    look(12'd115, 1'b1, 10'h00F, "R6 last entry intact");
    data(1'b1, 10'h2AA);
    run(cmdw(3'd2, 12'd105, 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    chk("R6 full cleared on next command", {31'h0, reg_rdata[4]}, 32'h0);
    look(12'd105, 1'b1, 10'h2AA, "R5 match found in full table");
    data(1'b0, 10'h000);
    run(cmdw(3'd2, 12'd250, 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    chk("R11 invalid load never sets full", {31'h0, reg_rdata[4]}, 32'h0);
    run(cmdw(3'd3, 12'd101, 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    data(1'b1, 10'h081);
    run(cmdw(3'd2, 12'd200, 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    look(12'd200, 1'b1, 10'h081, "R5 load into purged slot");
    look(12'd101, 1'b0, 10'h0, "R8 purged id gone");

    // R4 writes while busy are ignored
    run(cmdw(3'd1, 12'd0, 4'd0, 3'd0, 1'b0, 1'b1), cyc);
    look(12'd200, 1'b0, 10'h0, "R7 flush after full table");
    data(1'b1, 10'h011);
    wr(1'b0, cmdw(3'd2, 12'd40, 4'd0, 3'd0, 1'b0, 1'b1));
    wr(1'b1, 32'h0000_0BFF);
    wr(1'b0, cmdw(3'd3, 12'd40, 4'd0, 3'd0, 1'b0, 1'b1));
    wait_idle(cyc);
    look(12'd40, 1'b1, 10'h011, "R4 load used original data");
    chk("R4 command not replaced", reg_rdata, 32'h0028_0002);
    reg_sel = 1'b1; #1;
    chk("R4 data not replaced", reg_rdata, 32'h0000_0811);
    reg_sel = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule